// File: doc/BRIEF.md
# Multilevel Level-Shifted Carrier PWM Generator

This block produces the gate commands for the legs of a diode-clamped multilevel inverter. It uses sinusoidal PWM with several stacked triangular carriers. A single up/down counter with a programmable turnaround value forms the triangle. That counter, shifted into one band per level boundary, gives a stack of in-phase carriers that divide the signed reference range evenly. An external source supplies one signed reference sample per leg. The block compares each sample against every carrier.

For each leg, the number of carriers that the reference exceeds selects how many upper switches are on. Each lower switch is the complement of one upper switch. The block also reports the selected output step as a small signed code. A parameter picks three-level operation (two carriers, four switches per leg) or five-level operation (four carriers, eight switches per leg). All gate outputs and level codes are registered.

Top module: `spwm_multilevel`

## Requirements
- R1: There are LEVELS-1 carriers. A shared count starts at 0 after reset and rises by one per clock while it is below `period_i`. When it is not below `period_i`, it turns and falls by one. On reaching 0 while falling, it turns and rises, so with P = `period_i` > 0 the pattern repeats every 2P clocks. With P = 0 it stays at 0. Carrier i, counted from the bottom (i = 0..LEVELS-2), equals count + (i - (LEVELS-1)/2)·P.
- R2: Upper switch k (k = 1..LEVELS-1, carried on bit k-1 of the leg's `gate_hi_o` field) is on when the leg's reference is strictly greater than the k-th carrier counted from the top. The output appears one clock after the reference, period and count that produced it.
- R3: A reference exactly equal to a carrier leaves the corresponding upper switch off.
- R4: Lower switch k+LEVELS-1 (bit k-1 of the leg's `gate_lo_o` field) is always the inverse of upper switch k.
- R5: The leg's level code is a two's-complement value equal to the number of carriers exceeded minus (LEVELS-1)/2.
- R6: In three-level mode, a reference above both carriers turns on switches 1 and 2 (code +1). A reference between the carriers turns on switches 2 and 3 (code 0). A reference at or below the lower carrier turns on switches 3 and 4 (code -1).
- R7: In five-level mode, the codes +2, +1, 0, -1 and -2 are produced for references in the five bands. These correspond to +Vdc/2, +Vdc/4, 0, -Vdc/4 and -Vdc/2.
- R8: Each leg has its own reference and its own outputs. One leg's reference never affects another leg's outputs.
- R9: A clock edge with `rst` high puts every leg in the zero state: upper switches 1..(LEVELS-1)/2 off, the remaining upper switches on, and code 0. It also restarts the count at 0, rising.
- R10: With `period_i` held at 0, all carriers settle at 0 once the count has fallen to 0. A reference of 0 then gives all upper switches off, and a reference of 1 gives all of them on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | CNT_W | Triangle turnaround value P |
| ref_i | input | LEGS*REF_W | Signed reference per leg, leg g at bits g*REF_W +: REF_W |
| gate_hi_o | output | LEGS*(LEVELS-1) | Upper switch commands, leg g at g*(LEVELS-1) +: (LEVELS-1) |
| gate_lo_o | output | LEGS*(LEVELS-1) | Lower switch commands, same packing |
| level_o | output | LEGS*$clog2(LEVELS) | Signed level code per leg |

## Verification
Every gate and level result is due one rising edge after the reference and period that produce it. It is computed from the count value the design holds just before that edge. The bench drives stimulus on falling edges and keeps a count model that advances at each rising edge. At the rising edge it records the expected result from the inputs then present, and it compares the outputs on the following falling edge, so no comparison races the register update. The directed equality and band cases read the model count at the falling edge, because that is the count the next edge will use. Reset results are checked one edge after `rst` is sampled high.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  typedef enum logic {
    CNT_UP   = 1'b0,
    CNT_DOWN = 1'b1
  } cnt_dir_e;

  function automatic int unsigned carrier_total(int unsigned levels);
    return levels - 1;
  endfunction
endpackage

// File: rtl/spwm_carrier_gen.sv
module spwm_carrier_gen
  import spwm_pkg::*;
#(
  parameter int NCAR  = 4,
  parameter int CNT_W = 10,
  parameter int CMP_W = 14
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [CNT_W-1:0]             period_i,
  output logic [NCAR-1:0][CMP_W-1:0]   carrier_o
);
  localparam int HALF = NCAR / 2;

  cnt_dir_e          dir;
  logic [CNT_W-1:0]  cnt;
  logic signed [CMP_W-1:0] cnt_s, per_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      dir <= CNT_UP;
    end else begin
      case (dir)
        CNT_UP: begin
          if (cnt < period_i) begin
            cnt <= cnt + 1'b1;
          end else begin
            dir <= CNT_DOWN;
            cnt <= (cnt != '0) ? cnt - 1'b1 : '0;
          end
        end
        default: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            dir <= CNT_UP;
            cnt <= (period_i != '0) ? CNT_W'(1) : '0;
          end
        end
      endcase
    end
  end

  assign cnt_s = CMP_W'(cnt);
  assign per_s = CMP_W'(period_i);

  genvar g;
  for (g = 0; g < NCAR; g++) begin : g_band
    localparam logic signed [CMP_W-1:0] BAND = CMP_W'(g - HALF);
    assign carrier_o[g] = cnt_s + per_s * BAND;
  end

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1) ||
                     (cnt == $past(cnt) - 1'b1)));

  // R10
  flat_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(period_i) == '0 && $past(cnt) == '0) |-> cnt == '0);
endmodule

// File: rtl/spwm_leg.sv
module spwm_leg #(
  parameter int NCAR  = 4,
  parameter int REF_W = 12,
  parameter int CMP_W = 14,
  parameter int LVL_W = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic signed [REF_W-1:0]     ref_i,
  input  logic [NCAR-1:0][CMP_W-1:0]  carrier_i,
  output logic [NCAR-1:0]             gate_hi_o,
  output logic [NCAR-1:0]             gate_lo_o,
  output logic [LVL_W-1:0]            level_o
);
  localparam int HALF = NCAR / 2;
  localparam logic [NCAR-1:0] ZERO_HI = ~NCAR'((1 << HALF) - 1);
  localparam logic [NCAR-1:0] TOP_BIT = NCAR'(1) << (NCAR - 1);

  logic signed [CMP_W-1:0] ref_x;
  logic [NCAR-1:0]         above, hi_d, lo_d;
  logic [LVL_W-1:0]        ones, level_d;

  assign ref_x = CMP_W'(ref_i);

  genvar i;
  for (i = 0; i < NCAR; i++) begin : g_cmp
    assign above[i]          = ref_x > $signed(carrier_i[i]);
    assign hi_d[NCAR-1-i]    = above[i];
    assign lo_d[NCAR-1-i]    = ref_x <= $signed(carrier_i[i]);
  end

  always_comb begin
    ones = '0;
    for (int j = 0; j < NCAR; j++) begin
      ones = ones + LVL_W'(above[j]);
    end
    level_d = ones - LVL_W'(HALF);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      gate_hi_o <= ZERO_HI;
      gate_lo_o <= ~ZERO_HI;
      level_o   <= '0;
    end else begin
      gate_hi_o <= hi_d;
      gate_lo_o <= lo_d;
      level_o   <= level_d;
    end
  end

  // R4
  complement_chk: assert property (@(posedge clk) disable iff (rst)
    gate_lo_o == ~gate_hi_o);

  // R5
  level_match_chk: assert property (@(posedge clk) disable iff (rst)
    $signed(level_o) == $countones(gate_hi_o) - HALF);

  // R2
  stacked_chk: assert property (@(posedge clk) disable iff (rst)
    (gate_hi_o & ~(gate_hi_o >> 1) & ~TOP_BIT) == '0);

  // R9
  reset_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (gate_hi_o == ZERO_HI && level_o == '0));
endmodule

// File: rtl/spwm_multilevel.sv
module spwm_multilevel
  import spwm_pkg::*;
#(
  parameter int LEVELS = 5,
  parameter int LEGS   = 3,
  parameter int REF_W  = 12,
  parameter int CNT_W  = 10
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [CNT_W-1:0]                     period_i,
  input  logic [LEGS*REF_W-1:0]                ref_i,
  output logic [LEGS*(LEVELS-1)-1:0]           gate_hi_o,
  output logic [LEGS*(LEVELS-1)-1:0]           gate_lo_o,
  output logic [LEGS*$clog2(LEVELS)-1:0]       level_o
);
  localparam int NCAR  = int'(carrier_total(LEVELS));
  localparam int LVL_W = $clog2(LEVELS);
  localparam int CAR_W = CNT_W + $clog2(NCAR) + 1;
  localparam int CMP_W = ((CAR_W > REF_W) ? CAR_W : REF_W) + 1;

  if (LEVELS != 3 && LEVELS != 5) begin : g_bad_levels
    $error("LEVELS must be 3 or 5");
  end

  logic [NCAR-1:0][CMP_W-1:0] carriers;

  spwm_carrier_gen #(
    .NCAR (NCAR),
    .CNT_W(CNT_W),
    .CMP_W(CMP_W)
  ) u_carriers (
    .clk      (clk),
    .rst      (rst),
    .period_i (period_i),
    .carrier_o(carriers)
  );

  genvar g;
  for (g = 0; g < LEGS; g++) begin : g_leg
    spwm_leg #(
      .NCAR (NCAR),
      .REF_W(REF_W),
      .CMP_W(CMP_W),
      .LVL_W(LVL_W)
    ) u_leg (
      .clk      (clk),
      .rst      (rst),
      .ref_i    (ref_i[g*REF_W +: REF_W]),
      .carrier_i(carriers),
      .gate_hi_o(gate_hi_o[g*NCAR +: NCAR]),
      .gate_lo_o(gate_lo_o[g*NCAR +: NCAR]),
      .level_o  (level_o[g*LVL_W +: LVL_W])
    );
  end
endmodule

// File: tb/spwm_multilevel_test.sv
module spwm_multilevel_test;
  localparam int REF_W = 12;
  localparam int CNT_W = 10;
  localparam int LEGS  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CNT_W-1:0]      period = '0;
  logic [LEGS*REF_W-1:0] ref5 = '0;
  logic [LEGS*REF_W-1:0] ref3 = '0;
  logic [LEGS*4-1:0] hi5, lo5;
  logic [LEGS*3-1:0] lv5;
  logic [LEGS*2-1:0] hi3, lo3, lv3;

  always #10 clk = ~clk;

  spwm_multilevel #(.LEVELS(5), .LEGS(LEGS), .REF_W(REF_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .period_i(period), .ref_i(ref5),
    .gate_hi_o(hi5), .gate_lo_o(lo5), .level_o(lv5));

  spwm_multilevel #(.LEVELS(3), .LEGS(LEGS), .REF_W(REF_W), .CNT_W(CNT_W)) uut3 (
    .clk(clk), .rst(rst), .period_i(period), .ref_i(ref3),
    .gate_hi_o(hi3), .gate_lo_o(lo3), .level_o(lv3));

  int nchk = 0;
  int nfail = 0;
  int cycles = 0;
  int mcnt = 0;
  bit mdown = 1'b0;
  int e5_hi[LEGS], e5_lv[LEGS], e3_hi[LEGS], e3_lv[LEGS];

  function automatic int exp_hi(int r, int c, int p, int ncar);
    int v = 0;
    for (int k = 1; k <= ncar; k++)
      if (r > c + (ncar - k - ncar / 2) * p) v |= (1 << (k - 1));
    return v;
  endfunction

  function automatic int ones(int v);
    int n = 0;
    for (int b = 0; b < 4; b++) n += (v >> b) & 1;
    return n;
  endfunction

  // Expected outputs captured at each rising edge from the inputs present then
  always @(posedge clk) begin
    int p;
    p = int'(period);
    if (rst) begin
      for (int l = 0; l < LEGS; l++) begin
        e5_hi[l] = 12; e5_lv[l] = 0; e3_hi[l] = 2; e3_lv[l] = 0;
      end
      mcnt = 0; mdown = 1'b0;
    end else begin
      for (int l = 0; l < LEGS; l++) begin
        e5_hi[l] = exp_hi(int'($signed(ref5[l*REF_W +: REF_W])), mcnt, p, 4);
        e5_lv[l] = ones(e5_hi[l]) - 2;
        e3_hi[l] = exp_hi(int'($signed(ref3[l*REF_W +: REF_W])), mcnt, p, 2);
        e3_lv[l] = ones(e3_hi[l]) - 1;
      end
      if (!mdown) begin
        if (mcnt < p) mcnt++;
        else begin mdown = 1'b1; if (mcnt > 0) mcnt--; end
      end else begin
        if (mcnt > 0) mcnt--;
        else begin mdown = 1'b0; if (p > 0) mcnt = 1; end
      end
    end
  end

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 60000) begin
      nfail++;
      $display("FAIL watchdog expired actual=%0d expected<=60000", cycles);
      report();
      $finish;
    end
  end

  task automatic chk(string req, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set5(int l, int v);
    ref5[l*REF_W +: REF_W] = REF_W'(v);
  endtask

  task automatic set3(int l, int v);
    ref3[l*REF_W +: REF_W] = REF_W'(v);
  endtask

  function automatic int h5(int l); return int'(hi5[l*4 +: 4]); endfunction
  function automatic int v5(int l); return int'($signed(lv5[l*3 +: 3])); endfunction
  function automatic int h3(int l); return int'(hi3[l*2 +: 2]); endfunction
  function automatic int v3(int l); return int'($signed(lv3[l*2 +: 2])); endfunction

  task automatic compare_model();
    for (int l = 0; l < LEGS; l++) begin
      chk("R2", $sformatf("hi5 leg%0d", l), h5(l), e5_hi[l]);
      chk("R4", $sformatf("lo5 leg%0d", l), int'(lo5[l*4 +: 4]), int'(4'(~hi5[l*4 +: 4])));
      chk("R5", $sformatf("lv5 leg%0d", l), v5(l), e5_lv[l]);
      chk("R2", $sformatf("hi3 leg%0d", l), h3(l), e3_hi[l]);
      chk("R4", $sformatf("lo3 leg%0d", l), int'(lo3[l*2 +: 2]), int'(2'(~hi3[l*2 +: 2])));
      chk("R5", $sformatf("lv3 leg%0d", l), v3(l), e3_lv[l]);
    end
  endtask

  task automatic check_zero_state(string tag);
    for (int l = 0; l < LEGS; l++) begin
      chk(tag, $sformatf("zero hi5 leg%0d", l), h5(l), 12);
      chk(tag, $sformatf("zero lv5 leg%0d", l), v5(l), 0);
      chk(tag, $sformatf("zero hi3 leg%0d", l), h3(l), 2);
      chk(tag, $sformatf("zero lv3 leg%0d", l), v3(l), 0);
    end
  endtask

  initial begin
    int m;
    int p;
    void'($urandom(32'd7331));
    period = CNT_W'(4);
    repeat (3) @(negedge clk);
    // R9: state after reset
    check_zero_state("R9");

    // R1: period 4, reference 1 on leg0: switch 2 on only when count is 0
    rst = 1'b0;
    set5(0, 1);
    for (int n = 0; n < 16; n++) begin
      step();
      chk("R1", $sformatf("triangle cycle %0d", n), int'(hi5[1]), (n % 8 == 0) ? 1 : 0);
      compare_model();
    end

    // R6 / R3: three-level bands, period 8
    period = CNT_W'(8);
    repeat (3) begin step(); compare_model(); end
    m = mcnt;
    set3(0, m + 1); set3(1, m - 4); set3(2, m - 8);
    step();
    chk("R6", "3L above", h3(0), 3);  chk("R6", "3L above lvl", v3(0), 1);
    chk("R6", "3L between", h3(1), 2); chk("R6", "3L between lvl", v3(1), 0);
    chk("R3", "3L equal lower", h3(2), 0); chk("R6", "3L below lvl", v3(2), -1);
    compare_model();
    m = mcnt;
    set3(0, m); set3(1, m - 7); set3(2, m - 9);
    step();
    chk("R3", "3L equal upper", h3(0), 2);
    chk("R6", "3L between low", h3(1), 2);
    chk("R6", "3L below", h3(2), 0);
    compare_model();

    // R7 / R8: five-level bands, three legs at once
    m = mcnt;
    set5(0, m + 9); set5(1, m + 1); set5(2, m - 4);
    step();
    chk("R7", "5L lvl+2", v5(0), 2);  chk("R7", "5L lvl+1", v5(1), 1);
    chk("R7", "5L lvl0", v5(2), 0);
    chk("R8", "5L legs independent", h5(0) * 256 + h5(1) * 16 + h5(2), 15 * 256 + 14 * 16 + 12);
    compare_model();
    m = mcnt;
    set5(0, m - 12); set5(1, m - 16); set5(2, m + 8);
    step();
    chk("R7", "5L lvl-1", v5(0), -1); chk("R7", "5L lvl-2", v5(1), -2);
    chk("R3", "5L equal bottom", h5(1), 0);
    chk("R3", "5L equal top", h5(2), 14);
    chk("R8", "5L legs independent 2", h5(0) * 256 + h5(1) * 16 + h5(2), 8 * 256 + 0 * 16 + 14);
    compare_model();

    // Random phase with period changes and one mid-run reset
    for (int it = 0; it < 3000; it++) begin
      if (it % 250 == 0) period = CNT_W'($urandom_range(0, 40));
      p = int'(period);
      for (int l = 0; l < LEGS; l++) begin
        if ($urandom_range(0, 3) == 0) begin
          set5(l, int'($urandom_range(0, 4095)) - 2048);
          set3(l, int'($urandom_range(0, 4095)) - 2048);
        end else begin
          set5(l, int'($urandom_range(0, 4 * p + 6)) - (2 * p + 3));
          set3(l, int'($urandom_range(0, 2 * p + 6)) - (p + 3));
        end
      end
      rst = (it == 1500);
      if (it == 1500) begin set5(0, 2047); set3(0, -2048); end
      step();
      if (it == 1500) check_zero_state("R9");
      compare_model();
    end
    rst = 1'b0;

    // R10: period held at 0
    period = '0;
    set5(0, 0); set5(1, 1); set5(2, -1);
    set3(0, 0); set3(1, 1); set3(2, -1);
    repeat (60) begin step(); compare_model(); end
    chk("R10", "flat ref0 hi5", h5(0), 0);  chk("R10", "flat ref0 lv5", v5(0), -2);
    chk("R10", "flat ref1 hi5", h5(1), 15); chk("R10", "flat ref1 lv5", v5(1), 2);
    chk("R10", "flat ref-1 hi5", h5(2), 0);
    chk("R10", "flat ref1 hi3", h3(1), 3);  chk("R10", "flat ref0 hi3", h3(0), 0);

    report();
    $finish;
  end
endmodule